// File: doc/BRIEF.md
# PMIC I2C Single-Write Engine

This block is a small, dedicated I2C master. It does one job: it writes one byte into one register of a power-management device. Software programs three registers. The command register holds the target's 7-bit address, the register index, the data byte and a go flag. The clock register sets the SCL high and low times. The mode register holds options that software can read back.

Setting the go flag starts one bus transaction. The transaction is START, then the address byte with the write bit, then the register index, then the data byte, then STOP. The go flag clears itself when STOP is finished, so software polls that bit to see completion. If the target does not acknowledge a byte, the engine stops early. It still clears the go flag, and it raises a sticky error flag.

Both bus lines are open-drain. Each output is a pull-low enable, and a released line floats high.

Top module: `pmic_wr_engine`

## Requirements
- R1: Command register (select 0) layout. Bits [6:0] are the target address, [15:8] the register index, [23:16] the data byte, bit 24 the go flag and bit 25 the error flag. Bits [31:26] read 0. A write made while idle reads back exactly these fields.
- R2: A command write with bit 24 at 0 loads the fields but starts nothing. SCL and SDA stay released, and bit 24 reads 0.
- R3: A transaction puts these on the wire in order: one START, then the address byte {addr[6:0],0}, the register index and the data byte. Each byte goes out MSB first and is followed by a ninth (acknowledge) clock, during which the engine releases SDA. One STOP ends the transaction.
- R4: The clock register (select 1) holds the high count in bits [7:0] and the low count in bits [15:8]. Every SCL high pulse inside a transaction lasts high+5 clock cycles, and every SCL low phase lasts low+7 cycles.
- R5: With H = high+5, L = low+7 and k acknowledge slots completed, bit 24 clears exactly 1+(k+1)·L+(k+4)·H cycles after the clock edge that accepts the command. A full transfer has k = 27.
- R6: SDA changes while SCL is high only twice per transaction: once for START (falling) and once for STOP (rising).
- R7: If SDA reads high at the end of an acknowledge clock, the remaining bytes are skipped and STOP follows. Bit 25 and the `nack_err` output then read 1, and bit 24 still clears.
- R8: The error flag stays set after the failed transaction. It clears on the edge that accepts the next command with bit 24 set.
- R9: A command-register write while bit 24 reads 1 is ignored. The fields read back unchanged, the bytes sent are those of the first command, and no second transaction follows.
- R10: After reset, all three registers read 0, both bus outputs are released and `nack_err` is 0.
- R11: The clock register stores and reads back all 32 bits. The mode register (select 2) keeps only bits 6, 4, 3 and [2:0] and reads 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write: 0 command, 1 clock, 2 mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| sda_in | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| nack_err | output | 1 | Sticky error flag for a missing acknowledge |

## Verification
Register writes and reads take effect one edge after the write. The go flag therefore reads 1 on the first falling edge after the accepting edge, and the error flag clears on that same edge. Completion is timed by counting rising edges from the accepting edge until the go flag reads 0. That count must equal the R5 formula, which the bench computes from the programmed counts and from which byte it chose not to acknowledge.

A line monitor samples both lines on every falling clock edge. It decodes START, STOP, bytes and acknowledge bits, and it measures each SCL high and low phase in cycles. All of these are compared once the transaction has finished. Every sample is taken half a cycle away from the edge that moves the registers.

// File: rtl/pmic_wr_pkg.sv
// Shared constants and types for the PMIC write engine.
// Bit positions below are software-visible and must not move.
package pmic_wr_pkg;

    localparam int REG_W      = 32;
    localparam int SEL_W      = 2;
    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;

    // register selects
    localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CLK  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MODE = 2'd2;

    // command register fields
    localparam int CMD_ADDR_LSB = 0;
    localparam int CMD_IDX_LSB  = 8;
    localparam int CMD_DATA_LSB = 16;
    localparam int CMD_GO_BIT   = 24;
    localparam int CMD_ERR_BIT  = 25;

    // clock register fields
    localparam int CLK_HI_LSB = 0;
    localparam int CLK_LO_LSB = 8;

    // mode register: bits kept on write
    localparam logic [REG_W-1:0] MODE_KEEP = 32'h0000_005F;

    // fixed padding added to the programmed SCL counts
    localparam int HI_PAD = 5;
    localparam int LO_PAD = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ST_SU,   // lines released before START
        S_ST_HD,   // SDA low, SCL high
        S_B_LA,    // SCL low, SDA held
        S_B_LB,    // SCL low, SDA carries new bit
        S_B_HI,    // SCL high, bit valid
        S_P_LA,    // SCL low before STOP
        S_P_LB,    // SCL low, SDA pulled low
        S_P_SU,    // SCL high, SDA low
        S_P_HD     // both released after STOP
    } seq_state_t;

endpackage

// File: rtl/pmic_phase_timer.sv
// Down-counter that times one bus phase.
// Assumes: load_val is the phase length minus one. expire is high in the
// last cycle of the phase, and a load restarts the count.
module pmic_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/pmic_wr_regs.sv
// Software-visible registers: command, clock counts and mode.
// Assumes: the go bit stays set until the sequencer reports done, and
// command writes are dropped while it is set.
module pmic_wr_regs
    import pmic_wr_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              seq_done,
    input  logic              seq_nack,
    output logic              go,
    output logic              err,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BYTE_W-1:0] idx_byte,
    output logic [BYTE_W-1:0] data_byte,
    output logic [CFG_W-1:0]  hi_cnt,
    output logic [CFG_W-1:0]  lo_cnt
);

    logic [REG_W-1:0] clk_reg;
    logic [REG_W-1:0] mode_reg;
    logic             cmd_take;

    assign cmd_take = reg_wr && (reg_sel == SEL_CMD) && !go;

    // Command fields, go flag and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go        <= 1'b0;
            err       <= 1'b0;
            tgt_addr  <= '0;
            idx_byte  <= '0;
            data_byte <= '0;
        end else if (cmd_take) begin
            tgt_addr  <= reg_wdata[CMD_ADDR_LSB +: ADDR_W];
            idx_byte  <= reg_wdata[CMD_IDX_LSB +: BYTE_W];
            data_byte <= reg_wdata[CMD_DATA_LSB +: BYTE_W];
            go        <= reg_wdata[CMD_GO_BIT];
            if (reg_wdata[CMD_GO_BIT])
                err <= 1'b0;
        end else if (seq_done) begin
            go <= 1'b0;
            if (seq_nack)
                err <= 1'b1;
        end
    end

    // Clock and mode registers; writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_reg  <= '0;
            mode_reg <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_CLK)
                clk_reg <= reg_wdata;
            if (reg_sel == SEL_MODE)
                mode_reg <= reg_wdata & MODE_KEEP;
        end
    end

    assign hi_cnt = clk_reg[CLK_HI_LSB +: CFG_W];
    assign lo_cnt = clk_reg[CLK_LO_LSB +: CFG_W];

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CMD: begin
                reg_rdata[CMD_ADDR_LSB +: ADDR_W] = tgt_addr;
                reg_rdata[CMD_IDX_LSB +: BYTE_W]  = idx_byte;
                reg_rdata[CMD_DATA_LSB +: BYTE_W] = data_byte;
                reg_rdata[CMD_GO_BIT]             = go;
                reg_rdata[CMD_ERR_BIT]            = err;
            end
            SEL_CLK:  reg_rdata = clk_reg;
            SEL_MODE: reg_rdata = mode_reg;
            default:  reg_rdata = '0;
        endcase
    end

    // R9: a busy command write leaves the fields and the go flag untouched
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && reg_wr && reg_sel == SEL_CMD && !seq_done)
        |=> (go && $stable(tgt_addr) && $stable(idx_byte) && $stable(data_byte)));

    // R7: a refused byte leaves the error flag set
    p_err_on_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_nack) |=> err);

    // R5: completion from the sequencer drops the go flag
    p_done_clears_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !go);

endmodule

// File: rtl/pmic_wr_seq.sv
// Bus sequencer: START, three bytes, each followed by an acknowledge slot,
// then STOP. Each low phase is split into two halves, and SDA moves only
// at the halfway point. A refused byte jumps straight to STOP.
// Assumes: the fields and counts are stable while go is high.
module pmic_wr_seq
    import pmic_wr_pkg::*;
#(
    parameter int CFG_W = 8,
    parameter int CNT_W = CFG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [BYTE_W-1:0] idx_byte,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [CFG_W-1:0]  hi_cnt,
    input  logic [CFG_W-1:0]  lo_cnt,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              done,
    output logic              nack
);

    localparam int SLOT_BITS = BYTE_W + 1;
    localparam int BIT_W     = $clog2(SLOT_BITS + 1);
    localparam int NUM_BYTES = 3;
    localparam int BIDX_W    = $clog2(NUM_BYTES + 1);

    seq_state_t        state, nxt_state;
    logic [CNT_W-1:0]  len_hi, len_lo, len_la, len_lb, nxt_len;
    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIDX_W-1:0] byte_idx;
    logic              expire, step, slot_end, last_byte, ack_ok;

    assign len_hi    = CNT_W'(hi_cnt) + CNT_W'(HI_PAD);
    assign len_lo    = CNT_W'(lo_cnt) + CNT_W'(LO_PAD);
    assign len_la    = len_lo >> 1;
    assign len_lb    = len_lo - len_la;
    assign slot_end  = (bit_idx == BIT_W'(SLOT_BITS - 1));
    assign last_byte = (byte_idx == BIDX_W'(NUM_BYTES - 1));
    assign ack_ok    = !sda_in;
    assign step      = (state == S_IDLE) ? go : expire;
    assign done      = (state == S_P_HD) && expire;

    pmic_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step),
        .load_val (nxt_len - 1'b1),
        .expire   (expire)
    );

    // Next state and length of the phase that follows.
    always_comb begin
        nxt_state = S_IDLE;
        nxt_len   = CNT_W'(1);
        unique case (state)
            S_IDLE:  begin nxt_state = S_ST_SU; nxt_len = len_hi; end
            S_ST_SU: begin nxt_state = S_ST_HD; nxt_len = len_hi; end
            S_ST_HD: begin nxt_state = S_B_LA;  nxt_len = len_la; end
            S_B_LA:  begin nxt_state = S_B_LB;  nxt_len = len_lb; end
            S_B_LB:  begin nxt_state = S_B_HI;  nxt_len = len_hi; end
            S_B_HI: begin
                nxt_len   = len_la;
                nxt_state = (slot_end && (!ack_ok || last_byte)) ? S_P_LA : S_B_LA;
            end
            S_P_LA:  begin nxt_state = S_P_LB;  nxt_len = len_lb; end
            S_P_LB:  begin nxt_state = S_P_SU;  nxt_len = len_hi; end
            S_P_SU:  begin nxt_state = S_P_HD;  nxt_len = len_hi; end
            S_P_HD:  begin nxt_state = S_IDLE;  nxt_len = CNT_W'(1); end
            default: begin nxt_state = S_IDLE;  nxt_len = CNT_W'(1); end
        endcase
    end

    // State register and line drivers, updated at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            nack     <= 1'b0;
        end else if (step) begin
            state <= nxt_state;
            unique case (state)
                S_IDLE: begin
                    scl_oe   <= 1'b0;
                    sda_oe   <= 1'b0;
                    shreg    <= {tgt_addr, 1'b0};
                    bit_idx  <= '0;
                    byte_idx <= '0;
                    nack     <= 1'b0;
                end
                S_ST_SU: sda_oe <= 1'b1;
                S_ST_HD: scl_oe <= 1'b1;
                S_B_LA:  sda_oe <= slot_end ? 1'b0 : !shreg[BYTE_W-1];
                S_B_LB:  scl_oe <= 1'b0;
                S_B_HI: begin
                    scl_oe <= 1'b1;
                    if (slot_end) begin
                        bit_idx  <= '0;
                        byte_idx <= byte_idx + 1'b1;
                        shreg    <= (byte_idx == '0) ? idx_byte : data_byte;
                        if (!ack_ok)
                            nack <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= shreg << 1;
                    end
                end
                S_P_LA:  sda_oe <= 1'b1;
                S_P_LB:  scl_oe <= 1'b0;
                S_P_SU:  sda_oe <= 1'b0;
                default: ;
            endcase
        end
    end

    // R2: without go the engine stays idle with both lines released
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !go) |=> (state == S_IDLE && !scl_oe && !sda_oe));

    // R6: SDA is steady across SCL-high cycles except at START and STOP
    p_sda_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $past(state) != S_ST_SU && $past(state) != S_P_SU)
        |-> $stable(sda_oe));

endmodule

// File: rtl/pmic_wr_engine.sv
// Top of the PMIC single-write engine: registers plus bus sequencer.
// Assumes: open-drain bus outside this block; sda_in is the line level
// and already synchronous to clk.
module pmic_wr_engine
    import pmic_wr_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             nack_err
);

    localparam int CNT_W = CFG_W + 2;

    logic              go, seq_done, seq_nack;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BYTE_W-1:0] idx_byte, data_byte;
    logic [CFG_W-1:0]  hi_cnt, lo_cnt;

    pmic_wr_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .seq_done  (seq_done),
        .seq_nack  (seq_nack),
        .go        (go),
        .err       (nack_err),
        .tgt_addr  (tgt_addr),
        .idx_byte  (idx_byte),
        .data_byte (data_byte),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt)
    );

    pmic_wr_seq #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tgt_addr  (tgt_addr),
        .idx_byte  (idx_byte),
        .data_byte (data_byte),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (seq_done),
        .nack      (seq_nack)
    );

endmodule

// File: tb/pmic_wr_engine_tb.sv
`timescale 1ns/1ps
// Directed bench: a line monitor plus an acknowledging target model,
// and one task per scenario.
module pmic_wr_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe, nack_err;
    logic        slave_pull = 1'b0;
    logic        sda_in;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int nack_at = -1;

    always #2 clk = ~clk;  // 250 MHz

    assign sda_in = !(sda_oe || slave_pull);

    pmic_wr_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .nack_err(nack_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- line monitor and target model ----------------
    int   starts = 0, stops = 0, bitpos = 0, nbytes = 0;
    int   t_rise = -1, t_fall = -1, hmin, hmax, lmin, lmax;
    logic scl_p = 1'b1, sda_p = 1'b1, in_x = 1'b0, ackbit;
    logic [7:0] mshift;
    logic [7:0] mbytes [0:3];
    logic       macks  [0:3];

    always @(negedge clk) begin
        logic scl_now, sda_now;
        scl_now = !scl_oe;
        sda_now = !(sda_oe || slave_pull);
        if (scl_p && scl_now && sda_p && !sda_now) begin
            starts++; in_x = 1'b1; bitpos = 0; nbytes = 0;
            t_rise = -1; t_fall = -1;
            hmin = 100000; hmax = 0; lmin = 100000; lmax = 0;
        end else if (scl_p && scl_now && !sda_p && sda_now) begin
            stops++; in_x = 1'b0; bitpos = 0;
        end else if (!scl_p && scl_now) begin
            if (in_x && t_fall >= 0) begin
                if (cyc - t_fall < lmin) lmin = cyc - t_fall;
                if (cyc - t_fall > lmax) lmax = cyc - t_fall;
            end
            t_rise = cyc;
            if (bitpos < 8) mshift = {mshift[6:0], sda_now};
            else ackbit = sda_now;
            bitpos++;
        end else if (scl_p && !scl_now) begin
            if (in_x && t_rise >= 0) begin
                if (cyc - t_rise < hmin) hmin = cyc - t_rise;
                if (cyc - t_rise > hmax) hmax = cyc - t_rise;
            end
            t_fall = cyc;
            if (bitpos == 8) slave_pull = (nbytes != nack_at);
            else if (bitpos == 9) begin
                slave_pull = 1'b0;
                if (nbytes < 4) begin
                    mbytes[nbytes] = mshift;
                    macks[nbytes]  = ackbit;
                end
                nbytes++;
                bitpos = 0;
            end
        end
        scl_p = scl_now;
        sda_p = sda_now;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #0.5 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd(input logic [6:0] a, input logic [7:0] i,
                                        input logic [7:0] v, input logic g);
        return {7'd0, g, v, i, 1'b0, a};
    endfunction

    // full transaction with optional refused byte and optional busy write
    task automatic xfer(input string tag, input logic [6:0] a, input logic [7:0] i,
                        input logic [7:0] v, input logic [7:0] hi, input logic [7:0] lo,
                        input int nbyte, input int inj);
        int h, l, k, slots, n_exp, s0, p0, cnt, nb_exp;
        logic [31:0] r;
        logic [7:0] exp_b [0:2];
        h = hi + 5; l = lo + 7;
        slots  = (nbyte < 0) ? 27 : 9 * (nbyte + 1);
        nb_exp = (nbyte < 0) ? 3 : nbyte + 1;
        n_exp  = 1 + (slots + 1) * l + (slots + 4) * h;
        exp_b[0] = {a, 1'b0}; exp_b[1] = i; exp_b[2] = v;
        wr(2'd1, {8'h3C, 8'hC3, lo, hi});
        nack_at = nbyte;
        s0 = starts; p0 = stops;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = cmd(a, i, v, 1'b1);
        @(posedge clk);
        #1 reg_wr = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            #0.5;
            if (cnt == 0) begin
                check("R1", {tag, " readback after go"}, reg_rdata, cmd(a, i, v, 1'b1));
                check("R8", {tag, " error cleared on accept"}, nack_err, 0);
            end
            if (inj >= 0 && cnt == inj + 1)
                check("R9", {tag, " busy write ignored"}, reg_rdata, cmd(a, i, v, 1'b1));
            if (!reg_rdata[24] || cnt > 20000) break;
            if (cnt == inj) begin
                reg_wr = 1'b1; reg_wdata = 32'h01FF_EE5D;
            end
            @(posedge clk);
            #1 reg_wr = 1'b0;
            cnt++;
        end
        check("R5", {tag, " cycles to go clear"}, cnt, n_exp);
        check("R6", {tag, " START count"}, starts - s0, 1);
        check("R6", {tag, " STOP count"}, stops - p0, 1);
        check("R3", {tag, " byte count"}, nbytes, nb_exp);
        for (int b = 0; b < nb_exp; b++) begin
            check("R3", {tag, " byte on wire"}, mbytes[b], exp_b[b]);
            check("R3", {tag, " ack bit"}, macks[b], (b == nbyte) ? 1 : 0);
        end
        check("R4", {tag, " SCL high min"}, hmin, h);
        check("R4", {tag, " SCL high max"}, hmax, h);
        check("R4", {tag, " SCL low min"}, lmin, l);
        check("R4", {tag, " SCL low max"}, lmax, l);
        check("R7", {tag, " error flag port"}, nack_err, (nbyte >= 0) ? 1 : 0);
        rd(2'd0, r);
        check("R7", {tag, " error bit 25"}, r[25], (nbyte >= 0) ? 1 : 0);
        check("R8", {tag, " error still held"}, r[25], (nbyte >= 0) ? 1 : 0);
        repeat (40) @(negedge clk);
        check("R9", {tag, " no second transaction"}, starts - s0, 1);
        check("R2", {tag, " lines released after"}, {scl_oe, sda_oe}, 0);
        nack_at = -1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] r;
        rd(2'd0, r); check("R10", "command after reset", r, 0);
        rd(2'd1, r); check("R10", "clock after reset", r, 0);
        rd(2'd2, r); check("R10", "mode after reset", r, 0);
        check("R10", "bus outputs after reset", {scl_oe, sda_oe, nack_err}, 0);
    endtask

    task automatic t_cfg_regs();
        logic [31:0] r;
        wr(2'd1, 32'hA5B6_0503);
        rd(2'd1, r); check("R11", "clock readback", r, 32'hA5B6_0503);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r); check("R11", "mode keeps bits 6,4,3,2:0", r, 32'h0000_005F);
        wr(2'd2, 32'h0000_00A0);
        rd(2'd2, r); check("R11", "mode drops bit 5 and 7", r, 32'h0000_0000);
    endtask

    task automatic t_load_no_go();
        logic [31:0] r;
        int s0;
        s0 = starts;
        wr(2'd0, cmd(7'h2B, 8'h91, 8'h6E, 1'b0) | 32'hFC00_0000);
        rd(2'd0, r); check("R1", "fields without go", r, cmd(7'h2B, 8'h91, 8'h6E, 1'b0));
        repeat (60) begin
            @(negedge clk);
            if (scl_oe || sda_oe) begin
                check("R2", "line moved without go", {scl_oe, sda_oe}, 0);
                break;
            end
        end
        check("R2", "no START without go", starts - s0, 0);
        rd(2'd0, r); check("R2", "go bit stays 0", r[24], 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cfg_regs();
        t_load_no_go();
        xfer("base",      7'h5A, 8'h3C, 8'hA5, 8'd3,  8'd5,  -1, -1);
        xfer("min count", 7'h7F, 8'h00, 8'hFF, 8'd0,  8'd0,  -1, -1);
        xfer("nack addr", 7'h5A, 8'h3C, 8'hA5, 8'd3,  8'd5,   0, -1);
        xfer("nack data", 7'h11, 8'h22, 8'h33, 8'd3,  8'd5,   2, -1);
        xfer("busy write",7'h12, 8'h34, 8'h56, 8'd10, 8'd20, -1, 100);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule